// File: doc/BRIEF.md
# APB Protocol Monitor

This block is a passive checker that sits beside an APB requester/completer pair on a single clock. It watches the select, enable, ready, address, write and write-data lines, drives nothing, and reports each broken protocol rule in the cycle where it is broken. It follows every transfer from idle, through the setup cycle, into an access phase of any length. The access phase ends at the first cycle in which ready is seen high.

Each rule has its own one-cycle error pulse. A sticky summary flag records that any rule has been broken since reset, and a counter counts completed transfers. Address, data and counter widths are parameters. All lines are plain levels: the monitor only observes, so it has no valid/ready handshake and it never applies back-pressure.

Top module: `apb_watch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the monitor returns to idle, clears `any_err` and sets `xfer_count` to 0. With an idle bus, no error pulse is high after reset.
- R2: A transfer starts (setup cycle) only when `bus_sel` is high and was low in the previous cycle, or in the case of R9. If select stays high after a transfer has ended or been dropped, no new check starts and ready has no effect.
- R3: In a setup cycle with `bus_en` high, `err_early_en` is high in that same cycle.
- R4: In the first cycle after setup, if `bus_sel` is high and `bus_en` is low, `err_no_en` is high in that cycle and the transfer is dropped.
- R5: In any access-phase cycle before completion where `bus_sel` or `bus_en` is low (other than the R4 case), `err_abandon` is high in that cycle and the transfer is dropped.
- R6: In any access-phase cycle with `bus_sel` high, `err_unstable` is high in that cycle if `bus_addr`, `bus_wr` or `bus_wdata` differs from its value in the setup cycle. The completion cycle is included.
- R7: In any cycle with `bus_en` high and `bus_sel` low, `err_en_no_sel` is high in that cycle.
- R8: The access phase may last any number of cycles and ends at the first cycle in which `bus_sel`, `bus_en` and `bus_rdy` are all high. `xfer_count` rises by exactly 1, and the new value is visible after the next clock edge.
- R9: In the cycle after a completion, `bus_sel` high with `bus_en` low is a valid setup of a back-to-back transfer.
- R10: `any_err` goes high at the clock edge after any error pulse and stays high until reset.
- R11: `bus_rdy` outside the access phase does not change `xfer_count` and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Observed completer select |
| bus_en | input | 1 | Observed enable (access phase) |
| bus_rdy | input | 1 | Observed completer ready |
| bus_addr | input | ADDR_W | Observed address |
| bus_wr | input | 1 | Observed write/read direction |
| bus_wdata | input | DATA_W | Observed write data |
| err_early_en | output | 1 | Pulse: enable high in the setup cycle |
| err_no_en | output | 1 | Pulse: enable low in the first access cycle |
| err_abandon | output | 1 | Pulse: select or enable dropped before ready |
| err_unstable | output | 1 | Pulse: address, direction or data changed mid-transfer |
| err_en_no_sel | output | 1 | Pulse: enable high while select is low |
| any_err | output | 1 | Sticky summary of all error pulses |
| xfer_count | output | CNT_W | Completed transfer count |

## Verification
The bench holds select high after a dropped transfer, then raises enable and ready on that held select. A monitor that re-armed on a held level would start a new check there and would count a transfer or raise an error. It runs a back-to-back setup straight after completion. A monitor that needed a rising edge would miss that transfer and then flag its access cycle. It changes address or data on the completion cycle itself, which a check that stops one cycle early would miss. It also stretches the wait state to twenty cycles, and it pulses ready while idle to catch a counter that listens outside the access phase.

// File: rtl/apbw_pkg.sv
package apbw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_DONE   = 2'd2
  } phase_t;

  localparam int unsigned NUM_RULES = 5;

  typedef struct packed {
    logic early_en;
    logic no_en;
    logic abandon;
    logic unstable;
    logic en_no_sel;
  } rule_hits_t;

endpackage

// File: rtl/apbw_phase.sv
module apbw_phase
  import apbw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic en,
  input  logic rdy,
  output logic setup,
  output logic in_access,
  output logic done,
  output logic hit_early_en,
  output logic hit_no_en,
  output logic hit_abandon,
  output logic hit_en_no_sel
);

  phase_t st, st_nx;
  logic   sel_q;
  logic   first_q, first_nx;

  // Start only on a rising select, or on the cycle straight after a completion.
  always_comb begin
    setup = rst_n && sel && (st != PH_ACCESS) &&
            (!sel_q || ((st == PH_DONE) && !en));
  end

  assign in_access = (st == PH_ACCESS);

  always_comb begin
    st_nx         = st;
    first_nx      = 1'b0;
    done          = 1'b0;
    hit_no_en     = 1'b0;
    hit_abandon   = 1'b0;
    unique case (st)
      PH_ACCESS: begin
        if (first_q && sel && !en) begin
          hit_no_en = 1'b1;
          st_nx     = PH_IDLE;
        end else if (!(sel && en)) begin
          hit_abandon = 1'b1;
          st_nx       = PH_IDLE;
        end else if (rdy) begin
          done  = 1'b1;
          st_nx = PH_DONE;
        end
      end
      PH_DONE: st_nx = PH_IDLE;
      default: st_nx = PH_IDLE;
    endcase
    if (setup) begin
      st_nx    = PH_ACCESS;
      first_nx = 1'b1;
    end
  end

  assign hit_early_en  = setup && en;
  assign hit_en_no_sel = en && !sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PH_IDLE;
      sel_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      st      <= st_nx;
      sel_q   <= sel;
      first_q <= first_nx;
    end
  end

  // R2: a setup cycle always leads into the access phase
  assert_setup_leads_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setup |=> (st == PH_ACCESS));

  // R4: a missing enable drops the transfer
  assert_no_en_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_no_en && !setup) |=> (st == PH_IDLE));

  // R9: completion is followed by the post-completion phase
  assert_done_then_post_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (st == PH_DONE));

endmodule

// File: rtl/apbw_hold.sv
module apbw_hold #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup,
  input  logic              in_access,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit_unstable
);

  localparam int unsigned CTRL_W = ADDR_W + DATA_W + 1;

  logic [CTRL_W-1:0] snap_q;
  logic [CTRL_W-1:0] live;

  assign live = {wr, addr, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (setup) begin
      snap_q <= live;
    end
  end

  assign hit_unstable = in_access && sel && (live != snap_q);

  // R6: the snapshot holds the setup-cycle controls
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    setup |=> (snap_q == $past(live)));

endmodule

// File: rtl/apbw_tally.sv
module apbw_tally
  import apbw_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rule_hits_t       hits,
  input  logic             done,
  output logic             any_err,
  output logic [CNT_W-1:0] count
);

  logic hit_any;
  assign hit_any = |hits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_err <= 1'b0;
      count   <= '0;
    end else begin
      if (hit_any) any_err <= 1'b1;
      if (done)    count   <= count + 1'b1;
    end
  end

  // R10: the summary flag never falls while out of reset
  assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> any_err);

  // R8: each completion adds exactly one
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (count == $past(count) + 1'b1));

  // R11: without a completion the count holds
  assert_count_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(count));

endmodule

// File: rtl/apb_watch.sv
module apb_watch
  import apbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_rdy,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              err_early_en,
  output logic              err_no_en,
  output logic              err_abandon,
  output logic              err_unstable,
  output logic              err_en_no_sel,
  output logic              any_err,
  output logic [CNT_W-1:0]  xfer_count
);

  logic       setup, in_access, done;
  rule_hits_t hits;

  apbw_phase u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (bus_sel),
    .en            (bus_en),
    .rdy           (bus_rdy),
    .setup         (setup),
    .in_access     (in_access),
    .done          (done),
    .hit_early_en  (hits.early_en),
    .hit_no_en     (hits.no_en),
    .hit_abandon   (hits.abandon),
    .hit_en_no_sel (hits.en_no_sel)
  );

  apbw_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .setup        (setup),
    .in_access    (in_access),
    .sel          (bus_sel),
    .addr         (bus_addr),
    .wr           (bus_wr),
    .wdata        (bus_wdata),
    .hit_unstable (hits.unstable)
  );

  apbw_tally #(.CNT_W(CNT_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .hits    (hits),
    .done    (done),
    .any_err (any_err),
    .count   (xfer_count)
  );

  assign err_early_en  = hits.early_en;
  assign err_no_en     = hits.no_en;
  assign err_abandon   = hits.abandon;
  assign err_unstable  = hits.unstable;
  assign err_en_no_sel = hits.en_no_sel;

  // R3: early enable only arises with select high
  assert_early_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_early_en |-> (bus_sel && bus_en));

  // R5: an abandoned transfer never coincides with a completed one
  assert_abandon_not_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_abandon |-> !done);

endmodule

// File: tb/apb_watch_test.sv
`timescale 1ns/1ps
module apb_watch_test;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, en = 1'b0, rdy = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic e_early, e_noen, e_aband, e_unst, e_ens, any_err;
  logic [CW-1:0] cnt;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  apb_watch #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_en(en), .bus_rdy(rdy),
    .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .err_early_en(e_early), .err_no_en(e_noen), .err_abandon(e_aband),
    .err_unstable(e_unst), .err_en_no_sel(e_ens), .any_err(any_err),
    .xfer_count(cnt)
  );

  // Row: [31]sel [30]en [29]rdy [28]wr [27:20]addr [19:12]wdata
  //      [11:7] pulses {early(R3),no_en(R4),abandon(R5),unstable(R6),en_no_sel(R7)}
  //      [6:3] count seen before the edge, [2] any_err seen before the edge
  localparam int ROWS = 36;
  localparam logic [31:0] VEC [ROWS] = '{
    {4'b0000, 8'h00, 8'h00, 5'b00000, 4'd0, 3'b000}, // 0 idle
    {4'b0010, 8'h00, 8'h00, 5'b00000, 4'd0, 3'b000}, // 1 ready while idle R11
    {4'b1001, 8'hA1, 8'h11, 5'b00000, 4'd0, 3'b000}, // 2 setup
    {4'b1101, 8'hA1, 8'h11, 5'b00000, 4'd0, 3'b000}, // 3 wait
    {4'b1111, 8'hA1, 8'h11, 5'b00000, 4'd0, 3'b000}, // 4 complete
    {4'b0000, 8'h00, 8'h00, 5'b00000, 4'd1, 3'b000}, // 5 idle
    {4'b1001, 8'h22, 8'h12, 5'b00000, 4'd1, 3'b000}, // 6 setup
    {4'b1111, 8'h22, 8'h12, 5'b00000, 4'd1, 3'b000}, // 7 complete
    {4'b1001, 8'h33, 8'h13, 5'b00000, 4'd2, 3'b000}, // 8 back-to-back R9
    {4'b1101, 8'h33, 8'h13, 5'b00000, 4'd2, 3'b000}, // 9 wait
    {4'b1101, 8'h33, 8'h13, 5'b00000, 4'd2, 3'b000}, // 10 wait
    {4'b1111, 8'h33, 8'h13, 5'b00000, 4'd2, 3'b000}, // 11 complete
    {4'b0000, 8'h00, 8'h00, 5'b00000, 4'd3, 3'b000}, // 12 idle
    {4'b1100, 8'h44, 8'h14, 5'b10000, 4'd3, 3'b000}, // 13 early enable R3
    {4'b1110, 8'h44, 8'h14, 5'b00000, 4'd3, 3'b100}, // 14 complete, sticky R10
    {4'b0000, 8'h00, 8'h00, 5'b00000, 4'd4, 3'b100}, // 15 idle
    {4'b1000, 8'h55, 8'h15, 5'b00000, 4'd4, 3'b100}, // 16 setup
    {4'b1000, 8'h55, 8'h15, 5'b01000, 4'd4, 3'b100}, // 17 missing enable R4
    {4'b1000, 8'h55, 8'h15, 5'b00000, 4'd4, 3'b100}, // 18 held select R2
    {4'b1110, 8'h55, 8'h15, 5'b00000, 4'd4, 3'b100}, // 19 held select, ready R2
    {4'b0000, 8'h00, 8'h00, 5'b00000, 4'd4, 3'b100}, // 20 idle, no count
    {4'b1000, 8'h66, 8'h16, 5'b00000, 4'd4, 3'b100}, // 21 setup
    {4'b1100, 8'h66, 8'h16, 5'b00000, 4'd4, 3'b100}, // 22 wait
    {4'b0000, 8'h66, 8'h16, 5'b00100, 4'd4, 3'b100}, // 23 select dropped R5
    {4'b0000, 8'h00, 8'h00, 5'b00000, 4'd4, 3'b100}, // 24 idle
    {4'b1000, 8'h77, 8'h17, 5'b00000, 4'd4, 3'b100}, // 25 setup
    {4'b1100, 8'h78, 8'h17, 5'b00010, 4'd4, 3'b100}, // 26 address moved R6
    {4'b1110, 8'h77, 8'h18, 5'b00010, 4'd4, 3'b100}, // 27 data moved at completion R6
    {4'b0100, 8'h00, 8'h00, 5'b00001, 4'd5, 3'b100}, // 28 enable w/o select R7
    {4'b1000, 8'h88, 8'h19, 5'b00000, 4'd5, 3'b100}, // 29 setup
    {4'b1111, 8'h88, 8'h19, 5'b00010, 4'd5, 3'b100}, // 30 direction moved R6
    {4'b0000, 8'h00, 8'h00, 5'b00000, 4'd6, 3'b100}, // 31 idle
    {4'b1000, 8'h99, 8'h1A, 5'b00000, 4'd6, 3'b100}, // 32 setup
    {4'b1100, 8'h99, 8'h1A, 5'b00000, 4'd6, 3'b100}, // 33 wait
    {4'b1000, 8'h99, 8'h1A, 5'b00100, 4'd6, 3'b100}, // 34 enable dropped R5
    {4'b0000, 8'h00, 8'h00, 5'b00000, 4'd6, 3'b100}  // 35 idle
  };

  task automatic chk(input string tag, input int row, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s row %0d: actual=%0h expected=%0h", tag, row, got, exp);
    end
  endtask

  task automatic drive(input logic s, input logic e, input logic r, input logic w,
                       input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = s; en = e; rdy = r; wr = w; addr = a; wdata = d;
    #1;
  endtask

  task automatic pulses_zero(input string tag, input int row);
    chk(tag, row, {e_early, e_noen, e_aband, e_unst, e_ens}, 32'd0);
  endtask

  initial begin : watchdog
    #(5.0 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R1: reset state
    rst_n = 1'b0;
    repeat (3) drive(0, 0, 0, 0, 8'h00, 8'h00);
    chk("R1 count", -1, cnt, 0);
    chk("R1 any_err", -1, any_err, 0);
    pulses_zero("R1 pulses", -1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < ROWS; i++) begin
      logic [31:0] v;
      v = VEC[i];
      drive(v[31], v[30], v[29], v[28], v[27:20], v[19:12]);
      chk("R3 early", i, e_early, v[11]);
      chk("R4 no_en", i, e_noen, v[10]);
      chk("R5 abandon", i, e_aband, v[9]);
      chk("R6 unstable", i, e_unst, v[8]);
      chk("R7 en_no_sel", i, e_ens, v[7]);
      chk("R8 count", i, cnt, v[6:3]);
      chk("R10 any_err", i, any_err, v[2]);
    end

    // R1/R10: reset clears sticky flag and count
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 8'h00, 8'h00);
    drive(0, 0, 0, 0, 8'h00, 8'h00);
    chk("R10 cleared by reset", 100, any_err, 0);
    chk("R1 count cleared", 100, cnt, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: long wait state
    drive(1, 0, 0, 1, 8'h5A, 8'hC3);
    pulses_zero("R8 setup", 101);
    for (int k = 0; k < 20; k++) begin
      drive(1, 1, 0, 1, 8'h5A, 8'hC3);
      pulses_zero("R8 wait", 102 + k);
    end
    drive(1, 1, 1, 1, 8'h5A, 8'hC3);
    pulses_zero("R8 complete", 122);
    chk("R8 count before edge", 122, cnt, 0);
    drive(0, 0, 0, 0, 8'h00, 8'h00);
    chk("R8 long wait counted", 123, cnt, 1);
    chk("R10 clean run", 123, any_err, 0);

    // R11: ready held through idle cycles
    for (int k = 0; k < 3; k++) drive(0, 0, 1, 0, 8'h00, 8'h00);
    chk("R11 idle ready", 124, cnt, 1);
    pulses_zero("R11 pulses", 124);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule